// File: doc/BRIEF.md
# Interleaved-Channel Offset and Gain Calibrator

This block sits on the merged output of an M-way time-interleaved converter. Each valid sample is credited to a sub-converter by position: the n-th valid sample after an accepted batch start comes from channel n mod M. During a batch of M·2^LOGN samples, the block sums each channel's raw codes, which gives a mean. It also sums each channel's offset-corrected magnitudes, which serves as a power proxy. Channel 0 is the reference. When the batch closes, the offset of each channel is its mean minus the reference mean. Its inverse gain is the reference power divided by its own power.

The inverse gains come from one slow restoring divider that serves the channels in turn, so the sample path has no divider. The sample path needs only one multiplier, which applies the active estimates to every sample. The new offsets and inverse gains replace the old ones in a single step when the last division finishes, and `batch_done` pulses in that cycle. A system controller raises `batch_start` whenever it wants the estimates refreshed.

Top module: `tic_calibrator`

## Requirements
- R1: An accepted `batch_start` makes the sample of the same cycle channel 0. Each later valid sample advances the channel by one, wrapping from M-1 to 0. The count keeps running between batches.
- R2: A batch is M·2^LOGN valid samples. Offset estimate m = floor(S_m / 2^LOGN) − floor(S_0 / 2^LOGN), where S_m is the sum of channel m's raw codes in the batch. Channel 0's offset is always 0.
- R3: Power P_m is the sum over the batch of |x − off_m|, where off_m is the offset that is active while the batch runs.
- R4: Inverse gain m = min(65535, floor(P_0·2^15 / P_m)) in unsigned Q1.15 (32768 = 1.0). It is 32768 when P_m = 0. Channel 0 always holds 32768.
- R5: `out_sample` = sat(((x − off_c)·inv_c + 2^14) >>> 15) for the channel c of the input sample. It appears with `out_valid` one cycle after `in_valid`.
- R6: All estimates change together on the one-cycle `batch_done` pulse and are stable in every other cycle. Samples corrected while the divider runs use the old estimates.
- R7: After reset, all offsets are 0, all inverse gains are 32768, `out_valid` and `batch_done` are low, and correction is identity.
- R8: `batch_start` is ignored while a batch is accumulating or being divided. Channel counting and the running batch are unaffected.
- R9: A corrected value beyond the DW-bit signed range is clamped to −2^(DW−1) or 2^(DW−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed merged-stream sample |
| batch_start | input | 1 | Request to begin an estimation batch (honoured only when idle) |
| out_valid | output | 1 | Corrected sample strobe |
| out_sample | output | DW | Signed corrected sample |
| est_offset | output | M·(DW+1) | Signed offset of channel m in bits [m·(DW+1) +: DW+1] |
| est_inv_gain | output | M·16 | Q1.15 inverse gain of channel m in bits [m·16 +: 16] |
| batch_done | output | 1 | One-cycle pulse when new estimates take effect |

## Verification
The checks on the estimates assume that the controller raises `batch_start` only together with a valid sample. They also assume the stream is long enough for the divider to finish before the next start is honoured. The stimulus obeys both: it pairs every start with a sample, and it waits for `batch_done` before opening another batch. The stimulus uses a base waveform that is exactly sign-symmetric within each batch, so the injected offsets are recovered exactly. The recovered gains are checked against the injected ratios within a small tolerance. Bit-exact estimates and corrected outputs are computed arithmetically from the requirement formulas over a stepped sweep of the full input range.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int GAIN_FRAC = 15;
    localparam int INV_W     = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DIV  = 2'd2
    } cal_state_e;
endpackage

// File: rtl/tic_corrector.sv
module tic_corrector
    import tic_pkg::*;
#(
    parameter int DW = 12,
    parameter int OW = DW + 1
) (
    input  logic [DW-1:0]    sample,
    input  logic [OW-1:0]    offset,
    input  logic [INV_W-1:0] inv_gain,
    output logic [DW-1:0]    corrected,
    output logic [DW+1:0]    abs_diff
);
    localparam int XW  = DW + 2;
    localparam int PRW = XW + INV_W + 1;
    localparam logic signed [PRW-1:0] MAXV = PRW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [PRW-1:0] MINV = -MAXV - 1;
    localparam logic signed [PRW-1:0] HALF = PRW'(64'sd1 <<< (GAIN_FRAC - 1));

    logic signed [XW-1:0]  diff;
    logic signed [PRW-1:0] dx, gx, prod, rnd, shf;

    always_comb begin
        diff = $signed({sample[DW-1], sample[DW-1], sample}) - $signed({offset[OW-1], offset});
        abs_diff = diff[XW-1] ? XW'(-diff) : XW'(diff);
        dx   = PRW'(diff);
        gx   = $signed({{(PRW-INV_W){1'b0}}, inv_gain});
        prod = dx * gx;
        rnd  = prod + HALF;
        shf  = rnd >>> GAIN_FRAC;
        if (shf > MAXV)      corrected = MAXV[DW-1:0];
        else if (shf < MINV) corrected = MINV[DW-1:0];
        else                 corrected = shf[DW-1:0];
    end
endmodule

// File: rtl/tic_seq_divider.sv
module tic_seq_divider #(
    parameter int NW    = 33,
    parameter int DEN_W = 18,
    parameter int QW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NW-1:0]    num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [QW-1:0]    quot
);
    localparam int CNTW = $clog2(NW + 1);

    typedef struct packed {
        logic [DEN_W-1:0] rem;
        logic [NW-1:0]    sh;
        logic [NW-1:0]    q;
        logic [CNTW-1:0]  cnt;
        logic             busy;
        logic             done;
    } div_t;

    div_t dv_d, dv_q;
    logic [DEN_W:0] trial;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        trial     = {dv_q.rem, dv_q.sh[NW-1]};
        if (start) begin
            dv_d.rem  = '0;
            dv_d.sh   = num;
            dv_d.q    = '0;
            dv_d.cnt  = CNTW'(NW);
            dv_d.busy = 1'b1;
        end else if (dv_q.busy) begin
            if (trial >= {1'b0, den}) begin
                dv_d.rem = DEN_W'(trial - {1'b0, den});
                dv_d.q   = {dv_q.q[NW-2:0], 1'b1};
            end else begin
                dv_d.rem = trial[DEN_W-1:0];
                dv_d.q   = {dv_q.q[NW-2:0], 1'b0};
            end
            dv_d.sh  = dv_q.sh << 1;
            dv_d.cnt = dv_q.cnt - CNTW'(1);
            if (dv_q.cnt == CNTW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done = dv_q.done;
    assign quot = (|dv_q.q[NW-1:QW]) ? {QW{1'b1}} : dv_q.q[QW-1:0];
endmodule

// File: rtl/tic_calibrator.sv
module tic_calibrator
    import tic_pkg::*;
#(
    parameter int M    = 4,
    parameter int DW   = 12,
    parameter int LOGN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_sample,
    input  logic                 batch_start,
    output logic                 out_valid,
    output logic [DW-1:0]        out_sample,
    output logic [M*(DW+1)-1:0]  est_offset,
    output logic [M*INV_W-1:0]   est_inv_gain,
    output logic                 batch_done
);
    localparam int CW   = (M > 1) ? $clog2(M) : 1;
    localparam int BLEN = M << LOGN;
    localparam int BCW  = $clog2(BLEN);
    localparam int OW   = DW + 1;
    localparam int SW   = DW + LOGN;
    localparam int ABW  = DW + 2;
    localparam int PW   = ABW + LOGN;
    localparam int NW   = PW + GAIN_FRAC;
    localparam logic [INV_W-1:0] UNITY = INV_W'(1) << GAIN_FRAC;

    typedef struct packed {
        cal_state_e                st;
        logic [CW-1:0]             ch;
        logic [BCW-1:0]            cnt;
        logic [M-1:0][SW-1:0]      sum;
        logic [M-1:0][PW-1:0]      pw;
        logic [M-1:0][OW-1:0]      off;
        logic [M-1:0][INV_W-1:0]   inv;
        logic [M-1:0][INV_W-1:0]   inv_new;
        logic [CW-1:0]             dch;
        logic                      launch;
        logic                      done;
        logic                      ov;
        logic [DW-1:0]             od;
    } cal_t;

    cal_t st_d, st_q, st_rst;

    logic                  acc_ok, acc_en, div_done;
    logic [CW-1:0]         eff_ch;
    logic [BCW-1:0]        cnt_eff;
    logic [DW-1:0]         corr;
    logic [ABW-1:0]        absd;
    logic [INV_W-1:0]      div_q;
    logic [M-1:0][OW-1:0]  new_off;

    assign acc_ok  = (st_q.st == ST_IDLE) && batch_start;
    assign acc_en  = acc_ok || (st_q.st == ST_ACC);
    assign eff_ch  = acc_ok ? '0 : st_q.ch;
    assign cnt_eff = acc_ok ? '0 : st_q.cnt;

    for (genvar m = 0; m < M; m++) begin : g_off
        assign new_off[m] = OW'($signed(st_q.sum[m][SW-1:LOGN]))
                          - OW'($signed(st_q.sum[0][SW-1:LOGN]));
    end

    tic_corrector #(.DW(DW), .OW(OW)) u_corr (
        .sample    (in_sample),
        .offset    (st_q.off[eff_ch]),
        .inv_gain  (st_q.inv[eff_ch]),
        .corrected (corr),
        .abs_diff  (absd)
    );

    tic_seq_divider #(.NW(NW), .DEN_W(PW), .QW(INV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_q.launch),
        .num   ({st_q.pw[0], {GAIN_FRAC{1'b0}}}),
        .den   (st_q.pw[st_q.dch]),
        .done  (div_done),
        .quot  (div_q)
    );

    always_comb begin
        st_rst = '0;
        for (int m = 0; m < M; m++) begin
            st_rst.inv[m]     = UNITY;
            st_rst.inv_new[m] = UNITY;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.launch = 1'b0;
        st_d.ov     = in_valid;
        if (in_valid) begin
            st_d.od = corr;
            st_d.ch = (eff_ch == CW'(M - 1)) ? '0 : eff_ch + CW'(1);
        end else if (acc_ok) begin
            st_d.ch = '0;
        end

        if (acc_ok) begin
            st_d.st  = ST_ACC;
            st_d.cnt = '0;
            st_d.sum = '0;
            st_d.pw  = '0;
        end
        if (acc_en && in_valid) begin
            st_d.sum[eff_ch] = st_d.sum[eff_ch] + {{LOGN{in_sample[DW-1]}}, in_sample};
            st_d.pw[eff_ch]  = st_d.pw[eff_ch] + {{LOGN{1'b0}}, absd};
            if (cnt_eff == BCW'(BLEN - 1)) begin
                st_d.st     = ST_DIV;
                st_d.dch    = '0;
                st_d.launch = 1'b1;
            end else begin
                st_d.cnt = cnt_eff + BCW'(1);
            end
        end

        if (st_q.st == ST_DIV && div_done) begin
            st_d.inv_new[st_q.dch] = (st_q.pw[st_q.dch] == '0) ? UNITY : div_q;
            if (st_q.dch == CW'(M - 1)) begin
                st_d.st   = ST_IDLE;
                st_d.done = 1'b1;
                st_d.inv  = st_d.inv_new;
                st_d.off  = new_off;
            end else begin
                st_d.dch    = st_q.dch + CW'(1);
                st_d.launch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.ov;
    assign out_sample   = st_q.od;
    assign est_offset   = st_q.off;
    assign est_inv_gain = st_q.inv;
    assign batch_done   = st_q.done;
endmodule

// File: rtl/tic_calibrator_chk.sv
module tic_calibrator_chk
    import tic_pkg::*;
#(
    parameter int M  = 4,
    parameter int OW = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                out_valid,
    input logic [M*OW-1:0]     est_offset,
    input logic [M*INV_W-1:0]  est_inv_gain,
    input logic                batch_done
);
    localparam logic [INV_W-1:0] UNITY = INV_W'(1) << GAIN_FRAC;

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r5_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        batch_done |=> !batch_done);
    a_r6_estimates_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !batch_done |-> ($stable(est_offset) && $stable(est_inv_gain)));
    a_r2_ref_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        est_offset[OW-1:0] == '0);
    a_r4_ref_gain_unity: assert property (@(posedge clk) disable iff (!rst_n)
        est_inv_gain[INV_W-1:0] == UNITY);
endmodule

bind tic_calibrator tic_calibrator_chk #(.M(M), .OW(DW + 1)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .est_offset   (est_offset),
    .est_inv_gain (est_inv_gain),
    .batch_done   (batch_done)
);

// File: tb/tic_calibrator_tb.sv
module tic_calibrator_tb;
    localparam int M    = 4;
    localparam int DW   = 12;
    localparam int LOGN = 4;
    localparam int OW   = DW + 1;
    localparam int IW   = 16;
    localparam int PER  = 16;
    localparam int BLEN = M << LOGN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic batch_start = 1'b0;
    logic out_valid;
    logic [DW-1:0] out_sample;
    logic [M*OW-1:0] est_offset;
    logic [M*IW-1:0] est_inv_gain;
    logic batch_done;

    always #2 clk = ~clk;

    tic_calibrator #(.M(M), .DW(DW), .LOGN(LOGN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .batch_start(batch_start), .out_valid(out_valid), .out_sample(out_sample),
        .est_offset(est_offset), .est_inv_gain(est_inv_gain), .batch_done(batch_done)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int     a_off[M], a_inv[M];
    longint s_sum[M], s_pw[M];
    int     mch = 0;
    int     mst = 0;   // 0 idle, 1 accumulating, 2 dividing
    int     mcnt = 0;
    int     inj_off[M] = '{0, 25, -40, 12};
    int     inj_g[M]   = '{1000, 1100, 900, 1050};
    int     base[PER];

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_corr(input int x, input int off, input int inv);
        longint p;
        p = (longint'(x - off) * inv + 16384) >>> 15;
        if (p > 2047) p = 2047;
        if (p < -2048) p = -2048;
        return int'(p);
    endfunction

    function automatic int est_off(input int m);
        return int'($signed(est_offset[m*OW +: OW]));
    endfunction

    function automatic int est_inv(input int m);
        return int'(est_inv_gain[m*IW +: IW]);
    endfunction

    // one sample per cycle; checks the corrected output (R5)
    task automatic send(input int x, input bit st, input string req);
        int ch, exp, dif;
        if (st && mst == 0) begin
            mst = 1; mcnt = 0; mch = 0;
            for (int m = 0; m < M; m++) begin s_sum[m] = 0; s_pw[m] = 0; end
        end
        ch  = mch;
        exp = model_corr(x, a_off[ch], a_inv[ch]);
        if (mst == 1) begin
            dif = x - a_off[ch];
            s_sum[ch] += x;
            s_pw[ch]  += (dif < 0) ? -dif : dif;
            mcnt++;
            if (mcnt == BLEN) mst = 2;
        end
        mch = (mch + 1) % M;
        @(negedge clk);
        in_valid = 1'b1; in_sample = DW'(x); batch_start = st;
        @(posedge clk); #1;
        in_valid = 1'b0; batch_start = 1'b0;
        check({req, " out_valid"}, longint'(out_valid), 1);
        check(req, longint'($signed(out_sample)), exp);
    endtask

    task automatic align(input int ch);
        while (mch != ch) send(0, 1'b0, "R5 filler");
    endtask

    // waits for the estimate update and compares it with the model (R2 R4 R6)
    task automatic wait_done();
        int e_off[M], e_inv[M];
        int k;
        longint q;
        k = 0;
        while (batch_done !== 1'b1 && k < 3000) begin
            check("R6 estimates held", longint'(est_off(1)), a_off[1]);
            @(posedge clk); #1; k++;
        end
        if (k >= 3000) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog actual=no_done expected=batch_done");
        end
        for (int m = 0; m < M; m++) begin
            e_off[m] = int'((s_sum[m] >>> LOGN) - (s_sum[0] >>> LOGN));
            if (s_pw[m] == 0) e_inv[m] = 32768;
            else begin
                q = (s_pw[0] << 15) / s_pw[m];
                e_inv[m] = (q > 65535) ? 65535 : int'(q);
            end
            check($sformatf("R2 offset ch%0d", m), est_off(m), e_off[m]);
            check($sformatf("R4 inv gain ch%0d", m), est_inv(m), e_inv[m]);
            a_off[m] = e_off[m];
            a_inv[m] = e_inv[m];
        end
        mst = 0;
        @(posedge clk); #1;
        check("R6 done one cycle", longint'(batch_done), 0);
    endtask

    // one batch of symmetric base pattern with injected mismatch
    task automatic run_batch(input int start_ch, input bit poke_busy);
        int x, b;
        align(start_ch);
        for (int i = 0; i < BLEN; i++) begin
            b = (i / M < PER / 2) ? base[i / M] : -base[i / M - PER / 2];
            x = (b * inj_g[(i % M)]) / 1000 + inj_off[(i % M)];
            if (i == 0) send(x, 1'b1, "R1 first sample on ch0 R5");
            else if (poke_busy && i == 21) send(x, 1'b1, "R8 start ignored R5");
            else send(x, 1'b0, "R3 R5 batch sample");
        end
        // samples while dividing use old estimates; start ignored (R6 R8)
        for (int j = 0; j < 5; j++) send(100 * j - 200, j == 2, "R6 R8 old estimates");
        wait_done();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 12345;
        for (int m = 0; m < M; m++) begin a_off[m] = 0; a_inv[m] = 32768; end
        for (int k = 0; k < PER / 2; k++) begin
            seed = seed * 1103515245 + 12345;
            base[k] = 50 + ((seed >>> 8) & 255);
            if (((seed >>> 20) & 1) == 1) base[k] = -base[k];
        end
        repeat (4) @(posedge clk);
        #1;
        // R7 reset state
        for (int m = 0; m < M; m++) begin
            check("R7 reset offset", est_off(m), 0);
            check("R7 reset inv gain", est_inv(m), 32768);
        end
        check("R7 out_valid", longint'(out_valid), 0);
        check("R7 batch_done", longint'(batch_done), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R7 out_valid after release", longint'(out_valid), 0);
        for (int v = -2048; v < 2048; v += 301) send(v, 1'b0, "R7 identity");

        run_batch(1, 1'b1);
        // offsets recovered exactly from the symmetric stimulus
        for (int m = 0; m < M; m++) check("R2 injected offset", est_off(m), inj_off[m]);
        run_batch(3, 1'b0);
        for (int m = 1; m < M; m++) begin
            int ideal, err;
            ideal = (1000 * 32768) / inj_g[m];
            err   = est_inv(m) - ideal;
            if (err < 0) err = -err;
            check($sformatf("R4 gain tolerance ch%0d", m), longint'(err * 50 > ideal), 0);
        end
        // R1: start arriving on a non-zero channel count resets to ch0
        run_batch(2, 1'b1);

        // R5 sweep across the input range on all channels
        for (int v = -2048; v < 2048; v += 7) send(v, 1'b0, "R5 sweep");
        // R9 saturation on the channel with gain above one
        align(2);
        send(2047, 1'b0, "R9 high clamp model");
        check("R9 high clamp", longint'($signed(out_sample)), 2047);
        align(2);
        send(-2048, 1'b0, "R9 low clamp model");
        check("R9 low clamp", longint'($signed(out_sample)), -2048);
        @(posedge clk); #1;
        check("R5 idle out_valid", longint'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule